// File: doc/BRIEF.md
# Exception Stacking and Chaining Sequencer

This block decides when a pending exception is taken and then carries out the memory side of exception entry and return. On entry it writes an eight-word context frame below the current stack pointer, one word per cycle, and then issues a vector fetch request for the exception it has chosen. On return it reads the frame back and streams the restored words to the register file. If another exception qualifies at the moment of return, it skips both the frame reads and the frame writes and jumps straight to the next vector fetch.

Two shortcuts avoid repeated memory traffic. First, a more urgent exception that appears while the frame is being written only changes the vector fetch target, and the writes continue as before. This remains possible until the first instruction of the original handler executes. Second, tail-chaining at return reuses the frame already on the stack. Priority values run the other way from their size: a smaller number means more urgent. When two priorities are equal, the lower exception number wins. The number of the exception being handled is saved inside the stacked xPSR, so that a nested return restores it.

Top module: `exc_stack_seq`

## Requirements
- R1: A pending exception is taken only if `pend_pri < mask_lim` and either `thread_mode` is 1 or `pend_pri < cur_pri`. When it is taken, `mem_wr` rises on the cycle after the deciding clock edge.
- R2: If `pend_pri >= mask_lim`, the pending exception causes no memory write, no memory read and no vector request, however long it is held.
- R3: The frame has eight words. Word k goes to `frame_base + 4k`, and its data comes from `ctx_in[32k+31:32k]`. Counting k from 0, the order is R0, R1, R2, R3, R12, LR, PC, xPSR, so R0 sits at the lowest address.
- R4: `frame_base` is `sp_in - 32`. It is `sp_in - 36` only when `align_en` is 1 and `sp_in[2]` is 1. The cycle after the last write is accepted, `sp_we` pulses for one cycle and `sp_out` equals `frame_base`.
- R5: In the stacked xPSR, bit 9 is 1 exactly when the 4-byte gap was inserted. Bits 5:0 hold `act_num` at entry. All other bits come from `ctx_in`.
- R6: At most one write is issued per cycle, with addresses rising by 4. While `mem_rdy` is 0, `mem_wr`, `mem_addr` and `mem_wdata` hold their values.
- R7: A late arrival is a pending exception that passes the mask and beats the current target, meaning a lower priority value, or an equal priority value with a lower number. If one appears during stacking, or after stacking but before `first_exec`, it replaces the target. The frame writes are not affected. In the after-stacking case, `vec_req` pulses again.
- R8: `vec_req` pulses the cycle after the last write is accepted, with `vec_num` equal to the target. `act_num` takes the target on the cycle after `first_exec`.
- R9: On `exc_ret`, if a pending exception qualifies under the R1 rule, no memory access is made, `sp_we` stays low, and `vec_req` pulses on the next cycle for that exception.
- R10: On `exc_ret` with no qualifying exception, eight reads are made upward from `sp_in`. Each accepted read appears on `rest_valid`, `rest_idx` and `rest_data`. After the last read, `sp_out` is `sp_in + 32`, plus 4 if bit 9 of the restored xPSR is set. At the same point, `act_num` takes bits 5:0 of the restored xPSR.
- R11: After reset, `mem_wr`, `mem_rd`, `vec_req` and `sp_we` are 0, and `act_num` and `sp_out` are 0.
- R12: After `first_exec`, a more urgent exception does not count as a late arrival. It starts a new nested frame below the current `sp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_valid | input | 1 | A pending exception is offered |
| pend_num | input | 6 | Number of the offered exception |
| pend_pri | input | 3 | Priority of the offered exception (lower value is more urgent) |
| cur_pri | input | 3 | Current execution priority |
| mask_lim | input | 3 | Priority limit derived from the masks |
| thread_mode | input | 1 | The core is running thread code |
| align_en | input | 1 | Enables double-word alignment of the frame |
| sp_in | input | 32 | Current stack pointer |
| ctx_in | input | 256 | Register snapshot, eight 32-bit slots in frame order |
| first_exec | input | 1 | Pulse: first handler instruction reached execute |
| exc_ret | input | 1 | Pulse: the handler returns |
| mem_wr | output | 1 | Write request |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 32 | Word address of the request, in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while `mem_rdy` is high |
| mem_rdy | input | 1 | The memory accepts the current request |
| sp_out | output | 32 | New stack pointer |
| sp_we | output | 1 | One-cycle pulse: `sp_out` is updated |
| vec_req | output | 1 | Vector fetch request |
| vec_num | output | 6 | Exception whose vector is fetched |
| act_num | output | 6 | Exception being handled (0 in thread code) |
| rest_valid | output | 1 | A restored word is present |
| rest_idx | output | 3 | Slot of the restored word |
| rest_data | output | 32 | Restored word |

## Verification
The timing of each result is fixed:
- A taken exception puts its first write on the bus one cycle after the deciding edge.
- `sp_we` and the first `vec_req` follow one cycle after the final accepted write.
- A late arrival after stacking, or a tail-chain, raises `vec_req` one cycle after the edge that sees it.
- `act_num` changes one cycle after `first_exec`, or together with `sp_we` at the end of unstacking.

The bench drives inputs just after rising edges and samples on falling edges. A falling-edge monitor records every accepted write, accepted read, vector pulse and stack-pointer pulse. The checks then compare those counts and recorded values against frame addresses and xPSR contents that the bench computes from `sp_in`, `align_en` and the context words. The sweep covers two stack offsets, with alignment on and off, and with a memory that is either always ready or stalls on alternate cycles.

// File: rtl/exc_stack_seq.sv
module exc_stack_seq #(
  parameter int NUMW      = 6,
  parameter int PRIW      = 3,
  parameter int AW        = 32,
  parameter int ALIGN_BIT = 9   // must lie above the NUMW number field
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pend_valid,
  input  logic [NUMW-1:0] pend_num,
  input  logic [PRIW-1:0] pend_pri,
  input  logic [PRIW-1:0] cur_pri,
  input  logic [PRIW-1:0] mask_lim,
  input  logic            thread_mode,
  input  logic            align_en,
  input  logic [AW-1:0]   sp_in,
  input  logic [255:0]    ctx_in,
  input  logic            first_exec,
  input  logic            exc_ret,
  output logic            mem_wr,
  output logic            mem_rd,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_rdy,
  output logic [AW-1:0]   sp_out,
  output logic            sp_we,
  output logic            vec_req,
  output logic [NUMW-1:0] vec_num,
  output logic [NUMW-1:0] act_num,
  output logic            rest_valid,
  output logic [2:0]      rest_idx,
  output logic [31:0]     rest_data
);
  localparam logic [AW-1:0] FRAME_B = AW'(32);
  localparam logic [AW-1:0] GAP_B   = AW'(4);

  typedef enum logic [1:0] {S_RUN, S_STACK, S_WAIT, S_UNSTACK} st_t;

  st_t             st;
  logic [2:0]      idx;
  logic [AW-1:0]   base;
  logic            gap_q;
  logic            fetch_pend;
  logic [NUMW-1:0] tgt_num;
  logic [PRIW-1:0] tgt_pri;

  wire pass_mask = pend_valid && (pend_pri < mask_lim);
  wire can_enter = pass_mask && (thread_mode || (pend_pri < cur_pri));
  wire beats_tgt = pass_mask &&
                   ((pend_pri < tgt_pri) || ((pend_pri == tgt_pri) && (pend_num < tgt_num)));
  wire gap       = align_en && sp_in[2];
  wire [AW-1:0] entry_base = sp_in - FRAME_B - (gap ? GAP_B : '0);

  assign mem_wr     = (st == S_STACK);
  assign mem_rd     = (st == S_UNSTACK);
  assign mem_addr   = base + (AW'(idx) << 2);
  assign vec_req    = (st == S_WAIT) && fetch_pend;
  assign vec_num    = tgt_num;
  assign rest_valid = mem_rd && mem_rdy;
  assign rest_idx   = idx;
  assign rest_data  = mem_rdata;

  wire step = (mem_wr || mem_rd) && mem_rdy;
  wire last = (idx == 3'd7);

  always_comb begin
    mem_wdata = ctx_in[32*idx +: 32];
    if (last) begin
      mem_wdata[ALIGN_BIT]  = gap_q;
      mem_wdata[NUMW-1:0]   = act_num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      idx        <= '0;
      base       <= '0;
      gap_q      <= 1'b0;
      fetch_pend <= 1'b0;
      tgt_num    <= '0;
      tgt_pri    <= '0;
      act_num    <= '0;
      sp_out     <= '0;
      sp_we      <= 1'b0;
    end else begin
      sp_we <= 1'b0;
      case (st)
        S_RUN: begin
          if (exc_ret) begin
            if (can_enter) begin
              tgt_num    <= pend_num;
              tgt_pri    <= pend_pri;
              fetch_pend <= 1'b1;
              st         <= S_WAIT;
            end else begin
              base <= sp_in;
              idx  <= '0;
              st   <= S_UNSTACK;
            end
          end else if (can_enter) begin
            tgt_num <= pend_num;
            tgt_pri <= pend_pri;
            base    <= entry_base;
            gap_q   <= gap;
            idx     <= '0;
            st      <= S_STACK;
          end
        end
        S_STACK: begin
          if (beats_tgt) begin
            tgt_num <= pend_num;
            tgt_pri <= pend_pri;
          end
          if (step) begin
            idx <= idx + 3'd1;
            if (last) begin
              st         <= S_WAIT;
              fetch_pend <= 1'b1;
              sp_out     <= base;
              sp_we      <= 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (first_exec) begin
            act_num    <= tgt_num;
            fetch_pend <= 1'b0;
            st         <= S_RUN;
          end else if (beats_tgt) begin
            tgt_num    <= pend_num;
            tgt_pri    <= pend_pri;
            fetch_pend <= 1'b1;
          end else begin
            fetch_pend <= 1'b0;
          end
        end
        default: begin
          if (step) begin
            idx <= idx + 3'd1;
            if (last) begin
              sp_out  <= base + FRAME_B + (mem_rdata[ALIGN_BIT] ? GAP_B : '0);
              sp_we   <= 1'b1;
              act_num <= mem_rdata[NUMW-1:0];
              st      <= S_RUN;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/exc_stack_seq_chk.sv
module exc_stack_seq_chk #(
  parameter int AW   = 32,
  parameter int PRIW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_wr,
  input logic            mem_rd,
  input logic            mem_rdy,
  input logic [AW-1:0]   mem_addr,
  input logic [31:0]     mem_wdata,
  input logic            vec_req,
  input logic            sp_we,
  input logic            pend_valid,
  input logic [PRIW-1:0] pend_pri,
  input logic [PRIW-1:0] mask_lim
);
  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_rdy) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  // R3
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_rdy) |=> (!mem_wr || (mem_addr == $past(mem_addr) + AW'(4))));

  // R10
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_rdy) |=> (!mem_rd || (mem_addr == $past(mem_addr) + AW'(4))));

  // R2
  masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && (pend_pri >= mask_lim) && !mem_wr && !mem_rd && !vec_req) |=> !mem_wr);

  // R4
  sp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |=> !sp_we);

  // R8
  vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (!mem_wr && !mem_rd));
endmodule

bind exc_stack_seq exc_stack_seq_chk #(.AW(AW), .PRIW(PRIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdy(mem_rdy),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .vec_req(vec_req), .sp_we(sp_we),
  .pend_valid(pend_valid), .pend_pri(pend_pri), .mask_lim(mask_lim)
);

// File: tb/exc_stack_seq_test.sv
`timescale 1ns/1ps
module exc_stack_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pend_valid = 1'b0;
  logic [5:0] pend_num = '0;
  logic [2:0] pend_pri = '0, cur_pri = 3'd7, mask_lim = 3'd7;
  logic thread_mode = 1'b1, align_en = 1'b0;
  logic [31:0] sp_in = 32'h200;
  logic [255:0] ctx_in = '0;
  logic first_exec = 1'b0, exc_ret = 1'b0;
  logic mem_wr, mem_rd, mem_rdy, sp_we, vec_req, rest_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, sp_out, rest_data;
  logic [5:0] vec_num, act_num;
  logic [2:0] rest_idx;
  logic stall = 1'b0;

  logic [31:0] mem [0:255];
  logic [31:0] rest_arr [0:7];
  int wr_cnt, rd_cnt, vec_cnt, spwe_cnt;
  logic [5:0] last_vec;
  logic [31:0] last_sp;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  exc_stack_seq uut (
    .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_num(pend_num),
    .pend_pri(pend_pri), .cur_pri(cur_pri), .mask_lim(mask_lim),
    .thread_mode(thread_mode), .align_en(align_en), .sp_in(sp_in), .ctx_in(ctx_in),
    .first_exec(first_exec), .exc_ret(exc_ret), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .sp_out(sp_out), .sp_we(sp_we), .vec_req(vec_req), .vec_num(vec_num),
    .act_num(act_num), .rest_valid(rest_valid), .rest_idx(rest_idx), .rest_data(rest_data)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mem_rdy <= 1'b1;
    else mem_rdy <= stall ? ~mem_rdy : 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr && mem_rdy) begin mem[mem_addr[9:2]] <= mem_wdata; wr_cnt++; end
      if (rest_valid) begin rest_arr[rest_idx] <= rest_data; rd_cnt++; end
      if (vec_req) begin vec_cnt++; last_vec = vec_num; end
      if (sp_we) begin spwe_cnt++; last_sp = sp_out; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    wr_cnt = 0; rd_cnt = 0; vec_cnt = 0; spwe_cnt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pend_valid = 0; first_exec = 0; exc_ret = 0; stall = 0;
    thread_mode = 1; cur_pri = 3'd7; mask_lim = 3'd7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clr();
  endtask

  task automatic offer(input logic [5:0] num, input logic [2:0] pri);
    pend_valid = 1; pend_num = num; pend_pri = pri;
    @(negedge clk);
    pend_valid = 0;
  endtask

  task automatic wait_vec(input int want);
    for (int t = 0; t < 80 && vec_cnt < want; t++) @(negedge clk);
  endtask

  task automatic wait_spwe(input int want);
    for (int t = 0; t < 80 && spwe_cnt < want; t++) @(negedge clk);
  endtask

  task automatic pulse_exec();
    first_exec = 1; @(negedge clk); first_exec = 0; @(negedge clk);
  endtask

  task automatic fill_ctx(input int c);
    for (int k = 0; k < 7; k++) ctx_in[32*k +: 32] = 32'hA000_0000 + c*16 + k;
    ctx_in[224 +: 32] = 32'h0100_0000 | (c << 12);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    last_vec = '0; last_sp = '0; clr();
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 wr", {31'd0, mem_wr}, 0);
    chk("R11 rd", {31'd0, mem_rd}, 0);
    chk("R11 vec", {31'd0, vec_req}, 0);
    chk("R11 spwe", {31'd0, sp_we}, 0);
    chk("R11 act", {26'd0, act_num}, 0);
    chk("R11 sp", sp_out, 0);
    do_reset();

    // R2 masked and R1 non-outranking: never taken
    offer(6'd4, 3'd7);
    repeat (20) @(negedge clk);
    chk("R2 writes", wr_cnt, 0);
    chk("R2 vec", vec_cnt, 0);
    thread_mode = 0; cur_pri = 3'd2;
    offer(6'd4, 3'd3);
    repeat (20) @(negedge clk);
    chk("R1 no outrank", wr_cnt, 0);
    thread_mode = 1; cur_pri = 3'd7;

    // Sweep: stack offset x alignment x stall pattern (R1 R3 R4 R5 R6 R8 R10)
    for (int c = 0; c < 8; c++) begin
      logic [31:0] sp0, base, xp;
      logic g;
      do_reset();
      sp0 = (c & 1) ? 32'h204 : 32'h200;
      align_en = c[1];
      stall = c[2];
      g = align_en & sp0[2];
      base = sp0 - 32 - (g ? 4 : 0);
      xp = 32'h0100_0000 | (c << 12) | (g << 9);
      sp_in = sp0; fill_ctx(c);
      pend_valid = 1; pend_num = 6'd5; pend_pri = 3'd2;
      @(negedge clk);
      pend_valid = 0;
      chk("R1 write starts", {31'd0, mem_wr}, 1);
      wait_vec(1);
      chk("R6 write count", wr_cnt, 8);
      for (int k = 0; k < 7; k++) chk("R3 frame word", mem[(base >> 2) + k], 32'hA000_0000 + c*16 + k);
      chk("R5 stacked xPSR", mem[(base >> 2) + 7], xp);
      chk("R4 sp_out", last_sp, base);
      chk("R4 sp_we", spwe_cnt, 1);
      chk("R8 vec_num", {26'd0, last_vec}, 5);
      pulse_exec();
      chk("R8 act_num", {26'd0, act_num}, 5);
      sp_in = base;
      exc_ret = 1; @(negedge clk); exc_ret = 0;
      wait_spwe(2);
      chk("R10 reads", rd_cnt, 8);
      chk("R10 R0", rest_arr[0], 32'hA000_0000 + c*16);
      chk("R10 PC", rest_arr[6], 32'hA000_0006 + c*16);
      chk("R10 xPSR", rest_arr[7], xp);
      chk("R10 sp back", last_sp, sp0);
      chk("R10 act back", {26'd0, act_num}, 0);
    end

    // R7 late arrival during stacking and after stacking
    do_reset();
    stall = 1; align_en = 0; sp_in = 32'h200; fill_ctx(9);
    offer(6'd5, 3'd4);
    @(negedge clk);
    offer(6'd7, 3'd4);
    offer(6'd1, 3'd7);
    offer(6'd3, 3'd4);
    wait_vec(1);
    chk("R7 writes unchanged", wr_cnt, 8);
    chk("R7 frame R0", mem[(32'h1E0 >> 2)], 32'hA000_0090);
    chk("R7 tie winner", {26'd0, last_vec}, 3);
    chk("R7 one fetch", vec_cnt, 1);
    offer(6'd2, 3'd0);
    @(negedge clk);
    chk("R7 refetch", vec_cnt, 2);
    chk("R7 refetch num", {26'd0, last_vec}, 2);
    pulse_exec();
    chk("R7 act", {26'd0, act_num}, 2);

    // R9 tail-chain
    clr();
    exc_ret = 1; pend_valid = 1; pend_num = 6'd6; pend_pri = 3'd3;
    @(negedge clk);
    exc_ret = 0; pend_valid = 0;
    repeat (3) @(negedge clk);
    chk("R9 fetch", vec_cnt, 1);
    chk("R9 num", {26'd0, last_vec}, 6);
    chk("R9 no writes", wr_cnt, 0);
    chk("R9 no reads", rd_cnt, 0);
    chk("R9 no sp", spwe_cnt, 0);
    pulse_exec();
    chk("R9 act", {26'd0, act_num}, 6);

    // R12 nested preemption after first_exec
    do_reset();
    sp_in = 32'h200; align_en = 0; fill_ctx(3);
    offer(6'd5, 3'd4);
    wait_vec(1);
    pulse_exec();
    clr();
    sp_in = 32'h1E0; thread_mode = 0; cur_pri = 3'd4;
    offer(6'd8, 3'd4);
    repeat (10) @(negedge clk);
    chk("R1 equal pri not taken", wr_cnt, 0);
    offer(6'd9, 3'd1);
    wait_vec(1);
    chk("R12 nested writes", wr_cnt, 8);
    chk("R12 nested sp", last_sp, 32'h1C0);
    chk("R5 act saved", mem[(32'h1C0 >> 2) + 7], 32'h0100_3005);
    pulse_exec();
    chk("R12 act", {26'd0, act_num}, 9);
    sp_in = 32'h1C0;
    exc_ret = 1; @(negedge clk); exc_ret = 0;
    wait_spwe(2);
    chk("R10 nested act", {26'd0, act_num}, 5);
    chk("R10 nested sp", last_sp, 32'h1E0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule